// File: doc/BRIEF.md
# Transform-Domain LDPC Check Node Processor

This block performs the check node update of an iterative LDPC decoder with a transform-domain adder instead of a min/compare tree. Edge messages are 6-bit sign-magnitude values: bit 5 is the sign and bits 4:0 the magnitude. Each magnitude is mapped through a phi lookup table, the mapped values are added, and the saturated sum goes through the same table again. The sign of each outgoing message is the parity of the contributing input signs.

The processor alternates between two phases. In the receive phase it stores up to DEGREE incoming edge messages in arrival order. A one-cycle pulse on the phase-switch input moves it to the send phase. After one check node's worth of cycles, it emits one extrinsic message per edge on consecutive cycles, in the order the edges arrived. For the message of edge k, input k is left out of both the sum and the sign parity. Another pulse returns the processor to the receive phase. The adder has PORTS inputs; only the first DEGREE inputs are built with tables, and the rest are tied off.

Top module: `check_node_proc`

## Requirements
- R1: While rst_n is low, and until two clock edges after it rises, the processor sits in the receive phase with out_valid low and out_msg zero; out_msg is zero in every cycle in which out_valid is low.
- R2: In the receive phase, the first DEGREE cycles with in_valid high store in_msg as edges 0, 1, ... DEGREE-1 in that order. Idle cycles between them are allowed. Further in_valid cycles in the same phase leave the stored edges unchanged.
- R3: in_valid has no effect during the send phase.
- R4: A phase_rst pulse sampled in the receive phase starts the send phase. out_valid stays low for the next DEGREE-1 cycles and is then high for exactly DEGREE consecutive cycles.
- R5: The magnitude of the output for edge k is PHI(min(31, sum over stored edges j other than k of PHI(mag_j)))).
- R6: The sign bit of the output for edge k is the XOR of the sign bits of all stored edges other than k.
- R7: The outputs of one send phase are for edges 0 to DEGREE-1 in order.
- R8: A phase_rst pulse sampled in the send phase returns the processor to the receive phase, and out_valid is low from the next cycle.
- R9: When the mapped sum exceeds 31, the second table lookup uses 31.
- R10: The default PHI table maps 0 to 31, 1 to 8, 2 to 5, 3 to 4, 4 to 3, 5 and 6 to 2, 7 to 11 to 1, and 12 to 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_rst | input | 1 | One-cycle pulse that toggles between the receive and send phases |
| in_valid | input | 1 | Incoming edge message is present |
| in_msg | input | 6 | Incoming edge message, sign in bit 5 |
| out_valid | output | 1 | Outgoing extrinsic message is present |
| out_msg | output | 6 | Outgoing extrinsic message, sign in bit 5 |

## Verification
The assertions check four properties on every cycle:
- the output stays silent in the receive phase and in the first cycle of the send phase;
- it goes quiet right after any phase pulse;
- stores never land beyond edge DEGREE-1;
- successive outputs step through the edges one at a time.

The values themselves can only be shown by the bench scenarios. Its reference model recomputes the extrinsic magnitude and sign for every edge and checks them, together with:
- table saturation;
- ignored surplus and send-phase inputs;
- the exact latency and length of the output burst;
- abort in the middle of a burst.

// File: rtl/cnp_pkg.sv
package cnp_pkg;

  typedef enum logic {
    PH_RX = 1'b0,
    PH_TX = 1'b1
  } cnp_phase_e;

  localparam int DEF_MAG_W = 5;
  localparam int DEF_ENTRIES = 1 << DEF_MAG_W;

  // Default transform table: step of 0.25 on both axes, phi(x) = -ln(tanh(x/2)).
  function automatic int unsigned phi_point(input int unsigned x);
    if (x == 0)       return 31;
    else if (x == 1)  return 8;
    else if (x == 2)  return 5;
    else if (x == 3)  return 4;
    else if (x == 4)  return 3;
    else if (x <= 6)  return 2;
    else if (x <= 11) return 1;
    else              return 0;
  endfunction

  function automatic logic [DEF_ENTRIES*DEF_MAG_W-1:0] phi_table_default();
    logic [DEF_ENTRIES*DEF_MAG_W-1:0] tbl;
    tbl = '0;
    for (int i = 0; i < DEF_ENTRIES; i++) begin
      tbl[i*DEF_MAG_W +: DEF_MAG_W] = DEF_MAG_W'(phi_point(i));
    end
    return tbl;
  endfunction

endpackage

// File: rtl/cnp_phi_lut.sv
module cnp_phi_lut #(
  parameter int MAG_W = 5,
  parameter logic [(1<<MAG_W)*MAG_W-1:0] TABLE = cnp_pkg::phi_table_default()
) (
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0] phi_o
);

  always_comb begin
    phi_o = TABLE[mag_i*MAG_W +: MAG_W];
  end

endmodule

// File: rtl/cnp_ctrl.sv
module cnp_ctrl #(
  parameter int DEGREE = 6,
  parameter int PORTS  = 8
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     phase_rst,
  input  logic                     in_valid,
  output logic                     phase_tx,
  output logic                     wr_en,
  output logic [$clog2(PORTS)-1:0] wr_idx,
  output logic                     out_load,
  output logic [$clog2(PORTS)-1:0] edge_idx
);
  import cnp_pkg::*;

  localparam int IDX_W = $clog2(PORTS);
  localparam int RC_W  = $clog2(DEGREE + 1);
  localparam int CNT_W = $clog2(2 * DEGREE);
  localparam logic [RC_W-1:0]  RC_FULL = RC_W'(DEGREE);
  localparam logic [CNT_W-1:0] FIRST   = CNT_W'(DEGREE - 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(2 * DEGREE - 2);
  localparam logic [CNT_W-1:0] STOP    = CNT_W'(2 * DEGREE - 1);

  cnp_phase_e       phase_q, phase_d;
  logic [RC_W-1:0]  rcnt_q, rcnt_d;
  logic [CNT_W-1:0] scnt_q, scnt_d;
  logic [CNT_W-1:0] edge_full;
  logic             unused_edge_bits;

  assign phase_tx  = (phase_q == PH_TX);
  assign wr_en     = !phase_tx && !phase_rst && in_valid && (rcnt_q < RC_FULL);
  assign wr_idx    = IDX_W'(rcnt_q);
  assign out_load  = phase_tx && !phase_rst && (scnt_q >= FIRST) && (scnt_q <= LAST);
  assign edge_full = scnt_q - FIRST;
  assign edge_idx  = IDX_W'(edge_full);
  assign unused_edge_bits = ^edge_full;

  always_comb begin
    phase_d = phase_q;
    rcnt_d  = rcnt_q;
    scnt_d  = scnt_q;
    if (phase_rst) begin
      phase_d = phase_tx ? PH_RX : PH_TX;
      rcnt_d  = '0;
      scnt_d  = '0;
    end else if (!phase_tx) begin
      if (wr_en) rcnt_d = rcnt_q + 1'b1;
    end else if (scnt_q != STOP) begin
      scnt_d = scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_RX;
      rcnt_q  <= '0;
      scnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      rcnt_q  <= rcnt_d;
      scnt_q  <= scnt_d;
    end
  end

  // R7: consecutive outputs walk the edges one by one
  a_r7_edge_step: assert property (@(posedge clk) disable iff (!arst_n)
    (out_load && $past(out_load)) |-> (edge_idx == IDX_W'($past(edge_idx) + 1'b1)));

endmodule

// File: rtl/cnp_edge_store.sv
module cnp_edge_store #(
  parameter int DEGREE = 6,
  parameter int PORTS  = 8,
  parameter int MSG_W  = 6
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     wr_en,
  input  logic [$clog2(PORTS)-1:0] wr_idx,
  input  logic [MSG_W-1:0]         wr_msg,
  output logic [PORTS*MSG_W-1:0]   msgs_o
);

  localparam int IDX_W = $clog2(PORTS);

  for (genvar i = 0; i < PORTS; i++) begin : g_slot
    if (i < DEGREE) begin : g_live
      logic [MSG_W-1:0] slot_q;
      logic             slot_en;
      assign slot_en = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)      slot_q <= '0;
        else if (slot_en) slot_q <= wr_msg;
      end
      assign msgs_o[i*MSG_W +: MSG_W] = slot_q;
    end else begin : g_tie
      assign msgs_o[i*MSG_W +: MSG_W] = '0;
    end
  end

  // R2: no store targets an edge beyond the configured degree
  a_r2_store_bound: assert property (@(posedge clk) disable iff (!arst_n)
    wr_en |-> (int'(wr_idx) < DEGREE));

endmodule

// File: rtl/cnp_extrinsic.sv
module cnp_extrinsic #(
  parameter int DEGREE = 6,
  parameter int PORTS  = 8,
  parameter int MAG_W  = 5,
  parameter logic [(1<<MAG_W)*MAG_W-1:0] TABLE = cnp_pkg::phi_table_default()
) (
  input  logic [PORTS*(MAG_W+1)-1:0] msgs_i,
  input  logic [$clog2(PORTS)-1:0]   edge_idx,
  output logic [MAG_W:0]             res_o
);

  localparam int MSG_W = MAG_W + 1;
  localparam int IDX_W = $clog2(PORTS);
  localparam int SUM_W = MAG_W + $clog2(PORTS);
  localparam logic [SUM_W-1:0] SAT = SUM_W'((1 << MAG_W) - 1);

  logic [PORTS-1:0][MAG_W-1:0] term;
  logic [PORTS-1:0]            sgn;
  logic [SUM_W-1:0]            acc;
  logic [MAG_W-1:0]            sat_mag;
  logic [MAG_W-1:0]            out_mag;

  for (genvar i = 0; i < PORTS; i++) begin : g_port
    if (i < DEGREE) begin : g_used
      logic [MAG_W-1:0] mapped;
      logic             keep;
      cnp_phi_lut #(.MAG_W(MAG_W), .TABLE(TABLE)) u_in_lut (
        .mag_i (msgs_i[i*MSG_W +: MAG_W]),
        .phi_o (mapped)
      );
      assign keep    = (edge_idx != IDX_W'(i));
      assign term[i] = keep ? mapped : '0;
      assign sgn[i]  = keep & msgs_i[i*MSG_W + MAG_W];
    end else begin : g_off
      logic unused_port;
      assign unused_port = ^msgs_i[i*MSG_W +: MSG_W];
      assign term[i] = '0;
      assign sgn[i]  = 1'b0;
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < PORTS; i++) begin
      acc = acc + {{(SUM_W-MAG_W){1'b0}}, term[i]};
    end
    sat_mag = (acc > SAT) ? SAT[MAG_W-1:0] : acc[MAG_W-1:0];
  end

  cnp_phi_lut #(.MAG_W(MAG_W), .TABLE(TABLE)) u_out_lut (
    .mag_i (sat_mag),
    .phi_o (out_mag)
  );

  assign res_o = {^sgn, out_mag};

endmodule

// File: rtl/check_node_proc.sv
module check_node_proc #(
  parameter int DEGREE = 6,
  parameter int PORTS  = 8,
  parameter int MAG_W  = 5,
  parameter logic [(1<<MAG_W)*MAG_W-1:0] PHI_TABLE = cnp_pkg::phi_table_default()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_rst,
  input  logic             in_valid,
  input  logic [MAG_W:0]   in_msg,
  output logic             out_valid,
  output logic [MAG_W:0]   out_msg
);

  localparam int MSG_W = MAG_W + 1;
  localparam int IDX_W = $clog2(PORTS);

  logic [1:0]             sync_q;
  logic                   arst_n;
  logic                   phase_tx;
  logic                   wr_en;
  logic [IDX_W-1:0]       wr_idx;
  logic                   out_load;
  logic [IDX_W-1:0]       edge_idx;
  logic [PORTS*MSG_W-1:0] msgs;
  logic [MSG_W-1:0]       res;
  logic                   valid_q;
  logic [MSG_W-1:0]       msg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign arst_n = sync_q[1];

  cnp_ctrl #(.DEGREE(DEGREE), .PORTS(PORTS)) u_ctrl (
    .clk       (clk),
    .arst_n    (arst_n),
    .phase_rst (phase_rst),
    .in_valid  (in_valid),
    .phase_tx  (phase_tx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .out_load  (out_load),
    .edge_idx  (edge_idx)
  );

  cnp_edge_store #(.DEGREE(DEGREE), .PORTS(PORTS), .MSG_W(MSG_W)) u_store (
    .clk    (clk),
    .arst_n (arst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_msg (in_msg),
    .msgs_o (msgs)
  );

  cnp_extrinsic #(.DEGREE(DEGREE), .PORTS(PORTS), .MAG_W(MAG_W), .TABLE(PHI_TABLE)) u_ext (
    .msgs_i   (msgs),
    .edge_idx (edge_idx),
    .res_o    (res)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      valid_q <= out_load;
      msg_q   <= out_load ? res : '0;
    end
  end

  assign out_valid = valid_q;
  assign out_msg   = msg_q;

  // R1: nothing leaves while receiving
  a_r1_rx_silent: assert property (@(posedge clk) disable iff (!arst_n)
    !phase_tx |-> !out_valid);

  // R4: the first send cycle never carries data
  a_r4_first_gap: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(phase_tx) |-> !out_valid);

  // R8: a phase pulse silences the output on the next cycle
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    phase_rst |=> !out_valid);

endmodule

// File: tb/check_node_proc_tb.sv
module check_node_proc_tb;

  localparam int D = 6;

  logic       clk;
  logic       rst_n;
  logic       phase_rst;
  logic       in_valid;
  logic [5:0] in_msg;
  logic       out_valid;
  logic [5:0] out_msg;

  int checks = 0;
  int errors = 0;
  int burst  = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  check_node_proc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_rst (phase_rst),
    .in_valid  (in_valid),
    .in_msg    (in_msg),
    .out_valid (out_valid),
    .out_msg   (out_msg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R10: default table, written from the requirement
  function automatic int phi(input int x);
    if (x == 0) return 31;
    if (x == 1) return 8;
    if (x == 2) return 5;
    if (x == 3) return 4;
    if (x == 4) return 3;
    if (x < 7)  return 2;
    if (x < 12) return 1;
    return 0;
  endfunction

  // Behavioural reference model
  int        m_sync = 0;
  bit        m_tx   = 0;
  int        m_rcnt = 0;
  int        m_scnt = 0;
  logic [5:0] m_mem [D];
  bit        m_v    = 0;
  logic [5:0] m_out = '0;

  function automatic logic [5:0] ext_msg(input int k);
    int s;
    logic sg;
    s = 0;
    sg = 1'b0;
    for (int j = 0; j < D; j++) begin
      if (j != k) begin
        s += phi(int'(m_mem[j][4:0]));
        sg ^= m_mem[j][5];
      end
    end
    if (s > 31) s = 31;
    return {sg, 5'(phi(s))};
  endfunction

  always @(posedge clk) begin
    bit active;
    active = (m_sync >= 2);
    if (!rst_n) m_sync = 0;
    else if (m_sync < 2) m_sync++;
    if (!rst_n || !active) begin
      m_tx = 0; m_rcnt = 0; m_scnt = 0; m_v = 0; m_out = '0;
      for (int j = 0; j < D; j++) m_mem[j] = '0;
    end else if (phase_rst) begin
      m_tx = !m_tx; m_rcnt = 0; m_scnt = 0; m_v = 0; m_out = '0;
    end else if (!m_tx) begin
      m_v = 0; m_out = '0;
      if (in_valid && m_rcnt < D) begin
        m_mem[m_rcnt] = in_msg;
        m_rcnt++;
      end
    end else begin
      if (m_scnt >= D - 1 && m_scnt <= 2 * D - 2) begin
        m_v = 1;
        m_out = ext_msg(m_scnt - (D - 1));
      end else begin
        m_v = 0; m_out = '0;
      end
      if (m_scnt < 2 * D - 1) m_scnt++;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (out_valid !== m_v || out_msg !== m_out) begin
        errors++;
        $display("FAIL %s: out_valid/out_msg actual %b/%h expected %b/%h at %0t",
                 cur_req, out_valid, out_msg, m_v, m_out, $time);
      end
      if (out_valid) burst++;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [5:0] m);
    in_valid = 1'b1;
    in_msg   = m;
    @(negedge clk);
    in_valid = 1'b0;
    in_msg   = '0;
  endtask

  task automatic pulse();
    phase_rst = 1'b1;
    @(negedge clk);
    phase_rst = 1'b0;
  endtask

  // R4: latency, burst length, then back to receive
  task automatic send_and_check(input string req);
    cur_req = req;
    burst = 0;
    pulse();
    repeat (D - 1) @(negedge clk);
    check("R4 gap", {7'd0, out_valid}, 8'd0);
    @(negedge clk);
    check("R4 first", {7'd0, out_valid}, 8'd1);
    repeat (D + 2) @(negedge clk);
    check("R4 count", 8'(burst), 8'(D));
    pulse();
  endtask

  task automatic load(input logic [5:0] a, input logic [5:0] b, input logic [5:0] c,
                      input logic [5:0] d, input logic [5:0] e, input logic [5:0] f);
    push(a); push(b); push(c); push(d); push(e); push(f);
  endtask

  initial begin
    rst_n = 1'b0; phase_rst = 1'b0; in_valid = 1'b0; in_msg = '0;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    check("R1 valid", {7'd0, out_valid}, 8'd0);
    check("R1 msg", {2'd0, out_msg}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {7'd0, out_valid}, 8'd0);

    // R5 R6 R7 R10: mixed signs and magnitudes
    cur_req = "R5 R6 R7";
    load(6'h03, 6'h25, 6'h08, 6'h22, 6'h0C, 6'h24);
    send_and_check("R5 R6 R7");

    // R9: tiny magnitudes drive the sum past 31
    cur_req = "R9";
    load(6'h00, 6'h21, 6'h00, 6'h02, 6'h01, 6'h20);
    send_and_check("R9");

    // R2: surplus messages are dropped
    cur_req = "R2";
    load(6'h07, 6'h05, 6'h26, 6'h04, 6'h09, 6'h03);
    push(6'h20); push(6'h01);
    send_and_check("R2");

    // R3: inputs during the send phase are ignored
    cur_req = "R3";
    load(6'h0A, 6'h02, 6'h23, 6'h06, 6'h21, 6'h04);
    burst = 0;
    pulse();
    push(6'h20); push(6'h00); push(6'h3F);
    repeat (2 * D + 2) @(negedge clk);
    check("R3 count", 8'(burst), 8'(D));
    pulse();

    // R8: abort in the middle of a burst
    cur_req = "R8";
    load(6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07);
    pulse();
    repeat (D + 1) @(negedge clk);
    pulse();
    check("R8 quiet", {7'd0, out_valid}, 8'd0);
    cur_req = "R8 R2";
    load(6'h22, 6'h01, 6'h0B, 6'h24, 6'h02, 6'h23);
    send_and_check("R8 R2");

    // R2: idle cycles between stores
    cur_req = "R2 gaps";
    push(6'h04); @(negedge clk); push(6'h21); repeat (3) @(negedge clk);
    push(6'h06); push(6'h02); @(negedge clk); push(6'h28); push(6'h03);
    send_and_check("R2 gaps");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule